// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage. Each cycle fetch drives the address of the instruction it is fetching, and the block answers in the same cycle with a taken or not-taken guess, a flag saying whether a cached target exists for that address, and the address fetch should use next. The guess comes from a table of small saturating counters selected by low address bits. The target comes from a small buffer whose entries remember where recently taken branches went. Each entry is guarded by the upper address bits, so that a different branch sharing the same slot is not mistaken for the owner.

When a branch resolves, the later pipeline returns one update per cycle. The update carries the branch address, whether the branch went, where it went, and whether the earlier guess was wrong. The counter table and the target buffer learn from it independently. The counter steps toward the actual outcome. The target buffer only records branches that went. A wrong guess is turned straight back into a redirect request carrying the correct continuation address, so that the pipeline can discard younger work and restart fetch. The counter width is chosen at build time as one or two bits.

Top module: `branch_predictor`

## Requirements
- R1: After reset every address predicts not-taken, no target entry hits, and the next fetch address is the fetch address plus 4.
- R2: The counter is selected by address bits [DIR_IDX_W+1:2], so two addresses that differ only above those bits share one counter and predict alike.
- R3: With CTR_W=2 an update adds 1 to the counter when the branch went and subtracts 1 when it did not, staying within 0 to 3. Values 2 and 3 predict taken, and values 0 and 1 predict not-taken.
- R4: With CTR_W=1 the single bit predicts taken when it is 1. A taken update sets it and a not-taken update clears it.
- R5: The reset counter value is the weak not-taken state. A single taken update makes that address predict taken, in both widths.
- R6: A taken update writes the target entry at address bits [BTB_IDX_W+1:2], storing the bits above them as the tag and storing the actual target. A lookup hits only when the slot is valid and the tag matches, and a hit returns the stored target.
- R7: A not-taken update leaves the target buffer unchanged.
- R8: The next fetch address is the stored target when the guess is taken and the buffer hits. In every other case it is the fetch address plus 4.
- R9: While an update with the wrong-guess flag is present, redirect_valid is 1 and redirect_pc is the actual target if the branch went, or the branch address plus 4 if it did not. redirect_valid is 0 in every other cycle.
- R10: The prediction in a cycle reflects state before that cycle's update. The update becomes visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fet_pc | input | PC_W | Address being fetched |
| pred_taken | output | 1 | Direction guess for fet_pc |
| pred_hit | output | 1 | Target buffer holds an entry for fet_pc |
| pred_target | output | PC_W | Stored target, meaningful when pred_hit is 1 |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the branch |
| upd_target | input | PC_W | Actual target of the branch |
| upd_mispredict | input | 1 | The earlier guess for this branch was wrong |
| redirect_valid | output | 1 | Restart request for fetch |
| redirect_pc | output | PC_W | Address fetch must restart from |

## Verification
The learning properties compare a prediction with the one made one cycle later. They therefore assume that fetch holds the same address across those two cycles and that addresses are 4-byte aligned. The properties check nothing when the address changes between the two cycles. The stimulus changes its inputs only on the falling clock edge and uses only aligned addresses. It sets the wrong-guess flag from its own model of the wide-counter prediction, so the flag always agrees with what that instance guessed. The address set deliberately places several tags on each counter slot and on each buffer slot. This exercises aliasing and tag rejection, and the predictions the stimulus expects are worked out by simple counter arithmetic.

// File: rtl/bp_pkg.sv
// Shared helpers for the branch predictor.
// Assumes counter values fit in 32 bits.
package bp_pkg;

    // Saturating one-step move of a counter toward up (increment) or down.
    function automatic int unsigned sat_step(input int unsigned cur,
                                             input int unsigned top,
                                             input logic up);
        if (up)
            return (cur >= top) ? top : cur + 1;
        else
            return (cur == 0) ? 0 : cur - 1;
    endfunction

    // Weak not-taken value for a counter of the given width.
    function automatic int unsigned weak_not_taken(input int unsigned width);
        return (width <= 1) ? 0 : (1 << (width - 1)) - 1;
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
// Direction table: one saturating counter per slot, selected by an index
// that the parent cuts from the PC. The read is combinational and the write
// happens at the clock edge, so a read sees state from before the write.
// Assumes CTR_W is 1 or 2.
module bp_dir_table #(
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int unsigned CMAX = (1 << CTR_W) - 1;
    localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(bp_pkg::weak_not_taken(CTR_W));

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic [CTR_W-1:0] ctr_nxt;

    // Next value of the counter being trained.
    always_comb ctr_nxt = CTR_W'(bp_pkg::sat_step(32'(ctr_q[wr_idx]), CMAX, wr_taken));

    // Prediction bit: the counter itself for 1 bit, its upper bit otherwise.
    generate
        if (CTR_W == 1) begin : g_one
            assign rd_taken = ctr_q[rd_idx][0];
        end else begin : g_multi
            assign rd_taken = ctr_q[rd_idx][CTR_W-1];
        end
    endgenerate

    // Counter storage with reset to the weak not-taken state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_nxt;
        end
    end

endmodule

// File: rtl/bp_target_buf.sv
// Target buffer: direct-mapped slots holding a valid bit, a tag and the
// target of a branch that went. Lookup is combinational. Only valid bits
// are reset; the tag and target matter only once the valid bit is set.
module bp_target_buf #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int DEPTH = 1 << IDX_W;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    // Hit when the slot is valid and its tag matches the looked-up address.
    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

    // Valid bits: cleared by reset, set when an entry is allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target payload, written on allocation or refresh.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

endmodule

// File: rtl/branch_predictor.sv
// Fetch-side branch predictor. Combines a PC-indexed counter table with a
// tagged target buffer and turns wrong-guess updates into redirect requests.
// Assumes PCs are 4-byte aligned, and accepts at most one update per cycle.
module branch_predictor #(
    parameter int PC_W      = 32,
    parameter int DIR_IDX_W = 6,
    parameter int BTB_IDX_W = 4,
    parameter int CTR_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fet_pc,
    output logic            pred_taken,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispredict,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    localparam int TAG_W = PC_W - 2 - BTB_IDX_W;
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    bp_dir_table #(.IDX_W(DIR_IDX_W), .CTR_W(CTR_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fet_pc[DIR_IDX_W+1:2]),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[DIR_IDX_W+1:2]),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(.IDX_W(BTB_IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fet_pc[BTB_IDX_W+1:2]),
        .rd_tag    (fet_pc[PC_W-1:BTB_IDX_W+2]),
        .rd_hit    (pred_hit),
        .rd_target (pred_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_idx    (upd_pc[BTB_IDX_W+1:2]),
        .wr_tag    (upd_pc[PC_W-1:BTB_IDX_W+2]),
        .wr_target (upd_target)
    );

    // Next fetch address: follow the cached target only on a taken hit.
    always_comb pred_next_pc = (pred_taken && pred_hit) ? pred_target : fet_pc + STEP;

    // Redirect request with the correct continuation after a wrong guess.
    always_comb begin
        redirect_valid = upd_valid && upd_mispredict;
        redirect_pc    = upd_taken ? upd_target : upd_pc + STEP;
    end

endmodule

// File: rtl/bp_checker.sv
// Port-level properties of the branch predictor, attached by bind.
// Assumes fet_pc is held across two cycles whenever learning is compared.
module bp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fet_pc,
    input logic            pred_taken,
    input logic            pred_hit,
    input logic [PC_W-1:0] pred_target,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target
);
    logic seen_taken_q;

    // Records whether any taken update has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_taken_q <= 1'b0;
        else if (upd_valid && upd_taken) seen_taken_q <= 1'b1;
    end

    // R1
    reset_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_taken_q |-> !pred_hit);

    // R3
    taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && fet_pc == upd_pc && pred_taken)
        |=> ($stable(fet_pc) -> pred_taken));

    // R3
    not_taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && fet_pc == upd_pc && !pred_taken)
        |=> ($stable(fet_pc) -> !pred_taken));

    // R6
    alloc_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && fet_pc == upd_pc)
        |=> ($stable(fet_pc) -> (pred_hit && pred_target == $past(upd_target))));

    // R7
    keep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && fet_pc == upd_pc && pred_hit)
        |=> ($stable(fet_pc) -> (pred_hit && $stable(pred_target))));

    // R8
    always @(posedge clk) begin
        if (rst_n && !(pred_taken && pred_hit)) begin
            sequential_next_chk: assert (pred_next_pc == fet_pc + PC_W'(4));
        end
    end

endmodule

bind branch_predictor bp_checker #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fet_pc       (fet_pc),
    .pred_taken   (pred_taken),
    .pred_hit     (pred_hit),
    .pred_target  (pred_target),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
);

// File: tb/branch_predictor_test.sv
// Bench: small configuration (16-bit PC, 8 counters, 4 target slots),
// one 2-bit and one 1-bit instance fed the same stimulus, with a model kept
// by counter arithmetic and every probe address checked after each update.
module branch_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fet_pc = '0;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [PW-1:0] upd_target = '0;
    logic          upd_mispredict = 1'b0;

    logic          p_tk2, p_hit2, r_v2, p_tk1, p_hit1, r_v1;
    logic [PW-1:0] p_tgt2, p_nx2, r_pc2, p_tgt1, p_nx1, r_pc1;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    int            c2 [8];
    int            c1 [8];
    bit            bv [4];
    logic [11:0]   btag [4];
    logic [PW-1:0] btgt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_predictor #(.PC_W(PW), .DIR_IDX_W(3), .BTB_IDX_W(2), .CTR_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .fet_pc(fet_pc),
        .pred_taken(p_tk2), .pred_hit(p_hit2), .pred_target(p_tgt2), .pred_next_pc(p_nx2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict),
        .redirect_valid(r_v2), .redirect_pc(r_pc2));

    branch_predictor #(.PC_W(PW), .DIR_IDX_W(3), .BTB_IDX_W(2), .CTR_W(1)) uut_w1 (
        .clk(clk), .rst_n(rst_n), .fet_pc(fet_pc),
        .pred_taken(p_tk1), .pred_hit(p_hit1), .pred_target(p_tgt1), .pred_next_pc(p_nx1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict),
        .redirect_valid(r_v1), .redirect_pc(r_pc1));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mk_pc(input int tag, input int idx);
        return PW'((tag << 5) | (idx << 2));
    endfunction

    function automatic bit m_hit(input logic [PW-1:0] pc);
        return bv[pc[3:2]] && (btag[pc[3:2]] == pc[15:4]);
    endfunction

    // Probe one address on both instances against the model.
    task automatic probe(input logic [PW-1:0] pc, input bit at_reset);
        bit t2, t1, h;
        logic [PW-1:0] tg;
        @(negedge clk);
        fet_pc = pc;
        #1;
        t2 = c2[pc[4:2]] >= 2;
        t1 = c1[pc[4:2]] == 1;
        h  = m_hit(pc);
        tg = btgt[pc[3:2]];
        chk(at_reset ? "R1" : "R3", "2-bit taken", 32'(p_tk2), 32'(t2));
        chk(at_reset ? "R1" : "R4", "1-bit taken", 32'(p_tk1), 32'(t1));
        chk(at_reset ? "R1" : "R6", "hit", 32'(p_hit2), 32'(h));
        chk(at_reset ? "R1" : "R6", "hit 1-bit", 32'(p_hit1), 32'(h));
        if (h) chk("R6", "target", 32'(p_tgt2), 32'(tg));
        chk(at_reset ? "R1" : "R8", "next 2-bit", 32'(p_nx2), 32'((t2 && h) ? tg : pc + 16'd4));
        chk(at_reset ? "R1" : "R8", "next 1-bit", 32'(p_nx1), 32'((t1 && h) ? tg : pc + 16'd4));
    endtask

    task automatic probe_all(input bit at_reset);
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 8; i++) probe(mk_pc(t, i), at_reset);
    endtask

    // Present one update; check same-cycle prediction and redirect, then train the model.
    task automatic do_update(input logic [PW-1:0] pc, input bit tk, input logic [PW-1:0] tgt);
        bit old2, mis;
        @(negedge clk);
        old2 = c2[pc[4:2]] >= 2;
        mis  = (old2 != tk);
        fet_pc = pc; upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
        upd_target = tgt; upd_mispredict = mis;
        #1;
        chk("R10", "pre-update guess", 32'(p_tk2), 32'(old2));
        chk("R9", "redirect valid", 32'(r_v2), 32'(mis));
        chk("R9", "redirect valid 1-bit", 32'(r_v1), 32'(mis));
        if (mis) chk("R9", "redirect pc", 32'(r_pc2), 32'(tk ? tgt : pc + 16'd4));
        @(posedge clk);
        #1;
        upd_valid = 1'b0; upd_mispredict = 1'b0;
        c2[pc[4:2]] = tk ? ((c2[pc[4:2]] == 3) ? 3 : c2[pc[4:2]] + 1)
                         : ((c2[pc[4:2]] == 0) ? 0 : c2[pc[4:2]] - 1);
        c1[pc[4:2]] = tk ? 1 : 0;
        if (tk) begin
            bv[pc[3:2]] = 1'b1; btag[pc[3:2]] = pc[15:4]; btgt[pc[3:2]] = tgt;
        end
    endtask

    initial begin
        logic [31:0] rnd;
        logic [PW-1:0] a, al;
        for (int i = 0; i < 8; i++) begin c2[i] = 1; c1[i] = 0; end
        for (int i = 0; i < 4; i++) begin bv[i] = 1'b0; btag[i] = '0; btgt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe_all(1'b1);

        // R5: one taken update from reset flips both widths to taken
        a = mk_pc(0, 1);
        do_update(a, 1'b1, 16'h4440);
        probe(a, 1'b0);
        chk("R5", "2-bit after one taken", 32'(p_tk2), 32'd1);
        chk("R5", "1-bit after one taken", 32'(p_tk1), 32'd1);
        chk("R8", "next follows target", 32'(p_nx2), 32'h4440);

        // R2: alias with a different upper part shares the counter but misses on tag
        al = mk_pc(2, 1);
        probe(al, 1'b0);
        chk("R2", "alias shares counter", 32'(p_tk2), 32'd1);
        chk("R6", "alias tag rejected", 32'(p_hit2), 32'd0);
        chk("R8", "alias falls through", 32'(p_nx2), 32'(al + 16'd4));

        // R7: not-taken update keeps the target entry
        do_update(a, 1'b0, 16'h0000);
        probe(a, 1'b0);
        chk("R7", "entry kept", 32'(p_hit2), 32'd1);
        chk("R7", "target kept", 32'(p_tgt2), 32'h4440);
        chk("R3", "2-bit from 2 down to 1", 32'(p_tk2), 32'd0);
        chk("R4", "1-bit cleared", 32'(p_tk1), 32'd0);

        // R3: saturate at 3, one not-taken leaves 2-bit taken
        a = mk_pc(1, 6);
        for (int k = 0; k < 5; k++) do_update(a, 1'b1, 16'h1230);
        do_update(a, 1'b0, 16'h0000);
        probe(a, 1'b0);
        chk("R3", "saturated then one down", 32'(p_tk2), 32'd1);
        chk("R4", "1-bit follows last", 32'(p_tk1), 32'd0);
        for (int k = 0; k < 5; k++) do_update(a, 1'b0, 16'h0000);
        do_update(a, 1'b1, 16'h2220);
        probe(a, 1'b0);
        chk("R3", "floor then one up", 32'(p_tk2), 32'd0);

        // Mixed sweep over all probe addresses
        for (int n = 0; n < 300; n++) begin
            rnd = $urandom;
            a = mk_pc(int'(rnd[1:0]) % 3, int'(rnd[4:2]));
            do_update(a, rnd[8:6] != 3'd0 ? rnd[5] | rnd[9] : 1'b0, {rnd[27:14], 2'b00});
            probe_all(1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule